// File: doc/BRIEF.md
# Hub Reset and Attach Sequencer

This block runs the reset lifecycle of a USB hub device. After the active-low hardware reset pin is released, it filters out short glitches on that pin, waits a stabilization interval, and then opens a configuration window. In that window an embedded microcontroller writes the hub's configuration registers and reports completion. A fixed delay after the window closes, the block raises the upstream attach request. Every interval is counted by one shared down-counter that advances on a 1 µs tick input. The counter is reloaded each time the sequencer enters a new phase.

Once the hub is attached, a reset signalled by the upstream port starts a second job. The block issues one-cycle clear pulses for the device address, the configuration state and the transaction-translator buffers. It issues a resume pulse if the hub was suspended. It forces the power/indicator bits [3:2] of every downstream port control field to zero. The upstream reset is never passed on to the downstream ports: bit 0 of each port field (the downstream port-reset drive) and bit 1 pass through unchanged.

A request watchdog flags any request that the responder leaves waiting longer than the allowed response time. Requests use a valid/ready handshake. The requester raises `req_valid` and holds it until a cycle in which `req_ready` is also high. A request counts as pending in each cycle where `req_valid` is high and `req_ready` is low. The requester may not withdraw a request before it is accepted.

Top module: `hub_rst_seq`

## Requirements
- R1: A low level on `hw_reset_n` that spans at most FILT_US ticks is ignored. If the hub is attached, `attach` stays high.
- R2: A low level on `hw_reset_n` that spans FILT_US+1 or more ticks, in any phase, drops `attach` within a few cycles. The sequence then restarts from reset hold when the pin returns high.
- R3: After release, the sequencer spends STAB_US ticks in stabilization before the configuration window opens. `attach` never rises sooner than STAB_US+CFG_MIN_US+ATTACH_US ticks after release.
- R4: A `cfg_done` seen before CFG_MIN_US ticks of the window have elapsed is remembered, and the window then closes at CFG_MIN_US. A `cfg_done` that arrives later closes the window on the next cycle.
- R5: If no `cfg_done` arrives, the window closes after CFG_MAX_US ticks.
- R6: `attach` rises ATTACH_US ticks (plus at most a few cycles) after the configuration window closes, and stays high until a valid hardware reset.
- R7: While attached, a rising edge of `bus_reset` produces exactly one cycle of `addr_clr`, `cfg_clr` and `tt_clr` in the following cycle.
- R8: On that bus reset, bits [3:2] of every 4-bit port field in `port_ctl_o` are forced to 0. For a given port, this holds until that port's `port_ctl_i` bits [3:2] read 00. Bits [1:0] (bit 0 = downstream port-reset drive) always equal the input, so the reset is not propagated downstream.
- R9: `resume` pulses together with the clear pulses only when `suspended` is high at the bus reset.
- R10: A `bus_reset` before `attach` is high produces no pulse and no port masking.
- R11: When attached, a request pending for REQ_TMO_US ticks raises `req_timeout`. The flag stays high until the request is accepted. A request accepted sooner raises no flag.
- R12: During reset, `attach`, all pulses and `req_timeout` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Block reset, active low, asynchronous assert |
| hw_reset_n | input | 1 | External hardware reset pin, active low, asynchronous to clk |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| cfg_done | input | 1 | Microcontroller reports configuration finished |
| bus_reset | input | 1 | Upstream port is signalling a bus reset (level) |
| suspended | input | 1 | Hub is currently suspended |
| port_ctl_i | input | 4*N_PORTS | Port control fields from the register file, 4 bits per port |
| req_valid | input | 1 | Request is waiting for a response |
| req_ready | input | 1 | Responder takes the request this cycle |
| attach | output | 1 | Upstream attach request |
| addr_clr | output | 1 | Pulse: device address back to 0 |
| cfg_clr | output | 1 | Pulse: configuration back to unconfigured |
| tt_clr | output | 1 | Pulse: clear all transaction-translator buffers |
| resume | output | 1 | Pulse: leave suspend |
| port_ctl_o | output | 4*N_PORTS | Port control fields to the downstream ports |
| req_timeout | output | 1 | A request has waited past the response limit |

## Verification
The clear, resume and port-masking results for a bus reset are registered once, so they are due one cycle after the edge that first samples `bus_reset` high. The bench drives on the falling edge and samples at the next falling edge, then once more to confirm the pulse has ended. The hardware-reset filter has a two-stage synchronizer in front of it, so glitch and drop checks wait several cycles past the pin change before looking at `attach`. Phase timings are measured by counting cycles from release to the rise of `attach`, and the count is accepted within a small window above the tick sum to absorb the synchronizer and state-register latency. The watchdog is sampled a few cycles before and after its tick limit, and again just after acceptance.

// File: rtl/hub_rst_pkg.sv
package hub_rst_pkg;
  typedef enum logic [2:0] {
    ST_HOLD,
    ST_STAB,
    ST_CFG,
    ST_PREATT,
    ST_LIVE
  } seq_state_e;

  localparam int PORT_FW = 4;
  localparam logic [PORT_FW-1:0] PORT_NEG = 4'b1100;
endpackage

// File: rtl/hrs_pin_filter.sv
module hrs_pin_filter #(
  parameter int FILT_US = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  input  logic tick,
  output logic pin_high,
  output logic rst_act
);
  localparam int FT  = FILT_US + 1;
  localparam int CW  = $clog2(FT + 1);

  logic       s1_q, s2_q;
  logic [CW-1:0] cnt_q;
  logic       act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= pin_n;
      s2_q <= s1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (s2_q) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (tick && !act_q) begin
      if (cnt_q == CW'(FT - 1)) act_q <= 1'b1;
      else                      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign pin_high = s2_q;
  assign rst_act  = act_q;

  AST_ACT_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act_q) |-> !$past(s2_q)); // R2
endmodule

// File: rtl/hrs_timer.sv
module hrs_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         tick,
  output logic [W-1:0] cnt,
  output logic         expired
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt_q <= '0;
    else if (load)                  cnt_q <= load_val;
    else if (tick && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign cnt     = cnt_q;
  assign expired = (cnt_q == '0);
endmodule

// File: rtl/hrs_busrst.sv
module hrs_busrst
  import hub_rst_pkg::*;
#(
  parameter int N_PORTS = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         live,
  input  logic                         bus_reset,
  input  logic                         suspended,
  input  logic [PORT_FW*N_PORTS-1:0]   port_ctl_i,
  output logic                         addr_clr,
  output logic                         cfg_clr,
  output logic                         tt_clr,
  output logic                         resume,
  output logic [PORT_FW*N_PORTS-1:0]   port_ctl_o
);
  localparam int PW = PORT_FW * N_PORTS;

  logic br_q;
  logic rise;
  logic pulse_q, resume_q;
  logic [N_PORTS-1:0] mask_q;
  logic [PW-1:0] neg_all;

  assign rise = bus_reset && !br_q && live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      br_q     <= 1'b0;
      pulse_q  <= 1'b0;
      resume_q <= 1'b0;
    end else begin
      br_q     <= bus_reset;
      pulse_q  <= rise;
      resume_q <= rise && suspended;
    end
  end

  genvar p;
  generate
    for (p = 0; p < N_PORTS; p++) begin : g_port
      logic [PORT_FW-1:0] fin;
      assign fin = port_ctl_i[p*PORT_FW +: PORT_FW];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         mask_q[p] <= 1'b0;
        else if (!live)                     mask_q[p] <= 1'b0;
        else if (rise)                      mask_q[p] <= 1'b1;
        else if ((fin & PORT_NEG) == '0)    mask_q[p] <= 1'b0;
      end

      assign port_ctl_o[p*PORT_FW +: PORT_FW] =
        mask_q[p] ? (fin & ~PORT_NEG) : fin;
      assign neg_all[p*PORT_FW +: PORT_FW] = PORT_NEG;
    end
  endgenerate

  assign addr_clr = pulse_q;
  assign cfg_clr  = pulse_q;
  assign tt_clr   = pulse_q;
  assign resume   = resume_q;

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    addr_clr |=> !addr_clr); // R7
  AST_ONLY_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    addr_clr |-> $past(live)); // R10
  AST_PORT_NEG: assert property (@(posedge clk) disable iff (!rst_n)
    addr_clr |-> ((port_ctl_o & neg_all) == '0)); // R8
  AST_RESUME_SUSP: assert property (@(posedge clk) disable iff (!rst_n)
    resume |-> ($past(suspended) && addr_clr)); // R9
endmodule

// File: rtl/hrs_req_wdog.sv
module hrs_req_wdog #(
  parameter int REQ_TMO_US = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic tick,
  input  logic req_valid,
  input  logic req_ready,
  output logic timeout
);
  localparam int CW = $clog2(REQ_TMO_US + 1);

  logic          pend;
  logic [CW-1:0] cnt_q;

  assign pend = enable && req_valid && !req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  cnt_q <= '0;
    else if (!pend)                              cnt_q <= '0;
    else if (tick && cnt_q != CW'(REQ_TMO_US))   cnt_q <= cnt_q + 1'b1;
  end

  assign timeout = pend && (cnt_q == CW'(REQ_TMO_US));

  AST_TMO_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout) |-> $past(req_valid && enable)); // R11
endmodule

// File: rtl/hub_rst_seq.sv
module hub_rst_seq
  import hub_rst_pkg::*;
#(
  parameter int N_PORTS    = 4,
  parameter int FILT_US    = 1,
  parameter int STAB_US    = 500,
  parameter int CFG_MIN_US = 20000,
  parameter int CFG_MAX_US = 50000,
  parameter int ATTACH_US  = 1000,
  parameter int REQ_TMO_US = 5000
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       hw_reset_n,
  input  logic                       us_tick,
  input  logic                       cfg_done,
  input  logic                       bus_reset,
  input  logic                       suspended,
  input  logic [4*N_PORTS-1:0]       port_ctl_i,
  input  logic                       req_valid,
  input  logic                       req_ready,
  output logic                       attach,
  output logic                       addr_clr,
  output logic                       cfg_clr,
  output logic                       tt_clr,
  output logic                       resume,
  output logic [4*N_PORTS-1:0]       port_ctl_o,
  output logic                       req_timeout
);
  localparam int M1    = (STAB_US > ATTACH_US) ? STAB_US : ATTACH_US;
  localparam int MAXV  = (CFG_MAX_US > M1) ? CFG_MAX_US : M1;
  localparam int TW    = $clog2(MAXV + 1);
  localparam int MIN_LEFT = CFG_MAX_US - CFG_MIN_US;

  seq_state_e state_q, nxt;
  logic pin_high, rst_act;
  logic load;
  logic [TW-1:0] load_val, tcnt;
  logic tmr_expired;
  logic done_seen_q;
  logic min_ok;
  logic live;

  hrs_pin_filter #(.FILT_US(FILT_US)) u_filt (
    .clk(clk), .rst_n(rst_n), .pin_n(hw_reset_n), .tick(us_tick),
    .pin_high(pin_high), .rst_act(rst_act)
  );

  hrs_timer #(.W(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val),
    .tick(us_tick), .cnt(tcnt), .expired(tmr_expired)
  );

  assign min_ok = (tcnt <= TW'(MIN_LEFT));

  always_comb begin
    nxt = state_q;
    unique case (state_q)
      ST_HOLD:   if (!rst_act && pin_high) nxt = ST_STAB;
      ST_STAB:   if (tmr_expired) nxt = ST_CFG;
      ST_CFG:    if (tmr_expired || ((done_seen_q || cfg_done) && min_ok))
                   nxt = ST_PREATT;
      ST_PREATT: if (tmr_expired) nxt = ST_LIVE;
      ST_LIVE:   nxt = ST_LIVE;
      default:   nxt = ST_HOLD;
    endcase
    if (rst_act) nxt = ST_HOLD;
  end

  assign load = (nxt != state_q);

  always_comb begin
    unique case (nxt)
      ST_STAB:   load_val = TW'(STAB_US);
      ST_CFG:    load_val = TW'(CFG_MAX_US);
      ST_PREATT: load_val = TW'(ATTACH_US);
      default:   load_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_HOLD;
    else        state_q <= nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              done_seen_q <= 1'b0;
    else if (load)                           done_seen_q <= 1'b0;
    else if (state_q == ST_CFG && cfg_done)  done_seen_q <= 1'b1;
  end

  assign live   = (state_q == ST_LIVE);
  assign attach = live;

  hrs_busrst #(.N_PORTS(N_PORTS)) u_brst (
    .clk(clk), .rst_n(rst_n), .live(live), .bus_reset(bus_reset),
    .suspended(suspended), .port_ctl_i(port_ctl_i),
    .addr_clr(addr_clr), .cfg_clr(cfg_clr), .tt_clr(tt_clr),
    .resume(resume), .port_ctl_o(port_ctl_o)
  );

  hrs_req_wdog #(.REQ_TMO_US(REQ_TMO_US)) u_wdog (
    .clk(clk), .rst_n(rst_n), .enable(live), .tick(us_tick),
    .req_valid(req_valid), .req_ready(req_ready), .timeout(req_timeout)
  );

  AST_HWRST_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    rst_act |=> !attach); // R2
  AST_ATTACH_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(attach) |-> $past(state_q == ST_PREATT && tmr_expired)); // R6
  AST_CFG_EARLY_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CFG && nxt == ST_PREATT && !tmr_expired) |-> min_ok); // R4
  AST_STAB_TO_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STAB && !rst_act && !tmr_expired) |=> state_q == ST_STAB); // R3
endmodule

// File: tb/sim_hub_rst_seq.sv
module sim_hub_rst_seq;
  localparam int CLK_P  = 10;
  localparam int NP     = 4;
  localparam int FILT   = 2;
  localparam int STAB   = 50;
  localparam int CMIN   = 200;
  localparam int CMAX   = 500;
  localparam int ATT    = 30;
  localparam int TMO    = 40;
  localparam int SLACK  = 12;

  logic clk = 0, rst_n = 0, hw_reset_n = 1, us_tick = 1;
  logic cfg_done = 0, bus_reset = 0, suspended = 0;
  logic [4*NP-1:0] port_ctl_i = '0;
  logic req_valid = 0, req_ready = 0;
  logic attach, addr_clr, cfg_clr, tt_clr, resume, req_timeout;
  logic [4*NP-1:0] port_ctl_o;

  int n_chk = 0, n_err = 0;

  // bit 16 = suspended, bits 15:0 = port control input fields
  localparam logic [16:0] VEC [4] = '{
    17'h0_FFFF, 17'h1_5A3C, 17'h0_1234, 17'h1_CCCC
  };

  hub_rst_seq #(.N_PORTS(NP), .FILT_US(FILT), .STAB_US(STAB), .CFG_MIN_US(CMIN),
    .CFG_MAX_US(CMAX), .ATTACH_US(ATT), .REQ_TMO_US(TMO)) u0 (
    .clk(clk), .rst_n(rst_n), .hw_reset_n(hw_reset_n), .us_tick(us_tick),
    .cfg_done(cfg_done), .bus_reset(bus_reset), .suspended(suspended),
    .port_ctl_i(port_ctl_i), .req_valid(req_valid), .req_ready(req_ready),
    .attach(attach), .addr_clr(addr_clr), .cfg_clr(cfg_clr), .tt_clr(tt_clr),
    .resume(resume), .port_ctl_o(port_ctl_o), .req_timeout(req_timeout)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_rng(input int act, input int lo, input int hi, input string tag);
    n_chk++;
    if (act < lo || act > hi) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_attach(output int n);
    n = 0;
    while (!attach && n < 3000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic hw_pulse(input int len);
    hw_reset_n = 0;
    cyc(len);
    hw_reset_n = 1;
  endtask

  initial begin : watchdog
    #(CLK_P * 150000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin : main
    int n;
    logic [15:0] pin, pexp;
    // R12 reset state
    cyc(3);
    chk({attach, addr_clr, cfg_clr, tt_clr, resume, req_timeout}, 0, "R12 reset outputs");

    // R4/R3: done held from start -> window closes at minimum
    cfg_done = 1;
    rst_n = 1;
    wait_attach(n);
    chk_rng(n, STAB + CMIN + ATT, STAB + CMIN + ATT + SLACK, "R4 early done closes at min");
    cfg_done = 0;

    // R2: valid hardware reset drops attach
    hw_reset_n = 0;
    cyc(8);
    chk(attach, 0, "R2 valid hw reset drops attach");
    hw_reset_n = 1;

    // R5/R3: no done -> maximum window; R10 bus reset early ignored
    n = 0;
    port_ctl_i = 16'hFFFF;
    cyc(20); n = 20;
    bus_reset = 1;
    cyc(1); n++;
    chk({addr_clr, resume}, 0, "R10 bus reset before attach no pulse");
    chk(port_ctl_o, 16'hFFFF, "R10 bus reset before attach no mask");
    bus_reset = 0;
    begin
      int m;
      wait_attach(m);
      n += m;
    end
    chk_rng(n, STAB + CMAX + ATT, STAB + CMAX + ATT + SLACK, "R5 max window without done");
    chk_rng(n, STAB + CMIN + ATT + 1, 100000, "R3 attach not before minimum");

    // R4/R6: late done closes window next cycle, attach after ATT
    hw_pulse(8);
    cyc(STAB + CMIN + 100);
    chk(attach, 0, "R4 still in window");
    cfg_done = 1;
    cyc(1);
    cfg_done = 0;
    wait_attach(n);
    chk_rng(n, ATT, ATT + 4, "R6 attach delay after late done");

    // R1: glitch ignored
    hw_pulse(FILT);
    cyc(10);
    chk(attach, 1, "R1 short glitch ignored");

    // R7/R8/R9: vector table of bus resets
    for (int v = 0; v < 4; v++) begin
      pin = VEC[v][15:0];
      pexp = pin & ~16'hCCCC;
      suspended = VEC[v][16];
      port_ctl_i = pin;
      cyc(1);
      bus_reset = 1;
      cyc(1);
      chk({addr_clr, cfg_clr, tt_clr}, 3'b111, $sformatf("R7 clear pulses v%0d", v));
      chk(resume, VEC[v][16], $sformatf("R9 resume v%0d", v));
      chk(port_ctl_o, pexp, $sformatf("R8 ports masked v%0d", v));
      cyc(1);
      chk({addr_clr, cfg_clr, tt_clr, resume}, 0, $sformatf("R7 single pulse v%0d", v));
      chk(port_ctl_o, pexp, $sformatf("R8 mask held v%0d", v));
      bus_reset = 0;
      port_ctl_i = pin & ~16'hCCCC;
      cyc(2);
      port_ctl_i = pin;
      cyc(1);
      chk(port_ctl_o, pin, $sformatf("R8 mask released v%0d", v));
    end
    suspended = 0;

    // R11: watchdog
    req_valid = 1;
    cyc(TMO - 3);
    chk(req_timeout, 0, "R11 no timeout before limit");
    cyc(6);
    chk(req_timeout, 1, "R11 timeout after limit");
    req_ready = 1;
    cyc(1);
    chk(req_timeout, 0, "R11 timeout cleared on accept");
    req_valid = 0; req_ready = 0;
    cyc(2);
    req_valid = 1;
    cyc(TMO - 10);
    req_ready = 1;
    cyc(1);
    req_valid = 0; req_ready = 0;
    cyc(20);
    chk(req_timeout, 0, "R11 short request no flag");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule